// File: doc/BRIEF.md
# Successive Interference Cancellation Processor

This block is the detection core of a direct-sequence CDMA receiver. It holds one window of N received chip samples and a ±1 spreading code for each of K users. It visits the users one at a time, in a rank order supplied at start, with the strongest user first. For each user it correlates the current residual window against that user's code to form a soft bit estimate. It then rebuilds that user's share of the signal as the estimate times the code, and removes it chip by chip from the residual. The whole sweep runs twice. In the second sweep, each user's first-sweep share is restored to the residual just before that user is estimated again. Only the second-sweep estimates leave the block.

The window is held in a single-port store, so each pass touches one chip per clock cycle. The received samples are overwritten by the residual as the job runs, so chips must be reloaded before the next job. Chips and codes enter on two valid/ready streams that accept data only while the block is idle; `in_ready` and `code_ready` are low for the whole job. Estimates leave on a valid/ready stream. While `est_valid` is high and `est_ready` is low, the engine stalls and holds the offered user index and value. `start`, `busy` and `done` are plain level and pulse pins.

Top module: `sic_engine`

## Requirements
- R1: After reset, `busy`, `done` and `est_valid` are low, and `in_ready` and `code_ready` are high.
- R2: Chips accepted while idle fill window positions 0 to N-1 in arrival order, with the fill position returning to 0 at reset and at each accepted start. While busy, `in_ready` is low and `in_valid` has no effect on the window.
- R3: A code accepted while idle is stored for user `code_user`. Bit i of `code_bits` applies to chip i, with 1 meaning +1 and 0 meaning −1. While busy, `code_ready` is low and the stored codes do not change.
- R4: Users are processed in the order given by `rank_order`, where field j (bits j*UW up to j*UW+UW-1) names the j-th user. Estimates leave in that order, with `est_user` naming each one.
- R5: A soft estimate is the sum over all chips of code sign times residual chip, shifted arithmetically right by log2(N) (rounding toward minus infinity) and clamped to the 6-bit range −32..31.
- R6: After a user is estimated, every residual chip becomes chip − sign·estimate, clamped to the 8-bit range −128..127.
- R7: In the second sweep, each residual chip of user k first becomes chip + sign·(k's first-sweep estimate), clamped to 8 bits. The correlation of that sweep uses the restored chip.
- R8: The first sweep starts from the received window. Exactly K estimates, all from the second sweep, are emitted per job.
- R9: While `est_valid` is high and `est_ready` is low, `est_valid`, `est_user` and `est_value` hold their values on the next cycle.
- R10: `start` is ignored while `busy` is high; the job in progress completes unchanged.
- R11: `done` is high for exactly one cycle, after the last estimate has been accepted, and `busy` is low on the cycle after it.
- R12: With `est_ready` held high, `done` rises 2·N·K + (2·N+1)·K cycles after the clock edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Chip sample offered |
| in_ready | output | 1 | Chip sample can be accepted (idle) |
| in_sample | input | CW | Received chip, two's complement |
| code_valid | input | 1 | Spreading code offered |
| code_ready | output | 1 | Code can be accepted (idle) |
| code_user | input | UW | User the code belongs to |
| code_bits | input | N | Code, bit i for chip i, 1 = +1 |
| rank_order | input | K*UW | Processing order, field j = j-th user |
| start | input | 1 | Begin a job (sampled while idle) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| est_valid | output | 1 | Soft estimate offered |
| est_ready | input | 1 | Consumer accepts the estimate |
| est_user | output | UW | User of the offered estimate |
| est_value | output | EW | Second-sweep soft estimate, two's complement |

## Verification
In the second sweep, one clock cycle restores a chip by adding back a user's earlier share and also feeds that same restored value into the correlator. A wrong order of those two operations changes the estimate only when the restore saturates or the restored share is non-zero. The bench provokes this with a single-user window of known amplitude, which must come back at full amplitude after the restore. It also uses windows of near-full-scale samples whose restores clip at ±127/−128. Every estimate is compared with an integer model that applies the clamp between the restore and the accumulation.

// File: rtl/sic_pkg.sv
package sic_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_EMIT,
    ST_CANCEL,
    ST_FIN
  } sic_state_e;

endpackage

// File: rtl/sic_chip_buf.sv
module sic_chip_buf #(
  parameter int N  = 16,
  parameter int CW = 8,
  parameter int DW = 7,
  localparam int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [CW-1:0]        load_data,
  input  logic                 ptr_clr,
  input  logic [IW-1:0]        acc_idx,
  input  logic                 wr_en,
  input  logic signed [DW-1:0] delta,
  output logic signed [CW-1:0] upd
);
  localparam int SW = CW + 1;

  logic signed [CW-1:0] mem [N];
  logic [IW-1:0]        wr_ptr;
  logic [SW-1:0]        sum;

  // chip plus signed delta, one bit of headroom, then clamp
  always_comb begin
    sum = {mem[acc_idx][CW-1], mem[acc_idx]} + {{(SW-DW){delta[DW-1]}}, delta};
    if (sum[SW-1] != sum[SW-2])
      upd = sum[SW-1] ? {1'b1, {(CW-1){1'b0}}} : {1'b0, {(CW-1){1'b1}}};
    else
      upd = sum[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      if (ptr_clr) begin
        wr_ptr <= '0;
      end else if (load_en) begin
        mem[wr_ptr] <= load_data;
        wr_ptr <= (wr_ptr == IW'(N-1)) ? '0 : wr_ptr + 1'b1;
      end
      if (wr_en) mem[acc_idx] <= upd;
    end
  end

  // R2: host loads and datapath writes never share a cycle
  a_r2_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !wr_en);

endmodule

// File: rtl/sic_code_store.sv
module sic_code_store #(
  parameter int N = 16,
  parameter int K = 4,
  localparam int IW = $clog2(N),
  localparam int UW = $clog2(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [UW-1:0] load_user,
  input  logic [N-1:0]  load_bits,
  input  logic [UW-1:0] rd_user,
  input  logic [IW-1:0] rd_idx,
  output logic          sgn
);
  logic [N-1:0] codes [K];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < K; k++) codes[k] <= '0;
    end else if (load_en) begin
      codes[load_user] <= load_bits;
    end
  end

  assign sgn = codes[rd_user][rd_idx];

endmodule

// File: rtl/sic_despread.sv
module sic_despread #(
  parameter int N  = 16,
  parameter int CW = 8,
  parameter int EW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic                 sgn,
  input  logic signed [CW-1:0] chip,
  output logic signed [EW-1:0] est_next
);
  localparam int LG = $clog2(N);
  localparam int AW = CW + LG + 1;
  localparam int HI = (1 << (EW-1)) - 1;

  logic signed [AW-1:0] acc, chip_x, term, base, total, scaled, hi_x, lo_x;

  always_comb begin
    chip_x = {{(AW-CW){chip[CW-1]}}, chip};
    term   = sgn ? chip_x : -chip_x;
    base   = first ? '0 : acc;
    total  = base + term;
    scaled = total >>> LG;
    hi_x   = AW'(HI);
    lo_x   = -hi_x - 1;
    if (scaled > hi_x)      est_next = hi_x[EW-1:0];
    else if (scaled < lo_x) est_next = lo_x[EW-1:0];
    else                    est_next = scaled[EW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= total;
  end

endmodule

// File: rtl/sic_engine.sv
module sic_engine
  import sic_pkg::*;
#(
  parameter int N  = 16,
  parameter int K  = 4,
  parameter int CW = 8,
  parameter int EW = 6,
  localparam int UW = $clog2(K),
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CW-1:0]   in_sample,
  input  logic            code_valid,
  output logic            code_ready,
  input  logic [UW-1:0]   code_user,
  input  logic [N-1:0]    code_bits,
  input  logic [K*UW-1:0] rank_order,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            est_valid,
  input  logic            est_ready,
  output logic [UW-1:0]   est_user,
  output logic [EW-1:0]   est_value
);
  localparam int DW = EW + 1;

  sic_state_e           state;
  logic                 stage;
  logic [UW-1:0]        pos;
  logic [IW-1:0]        idx;
  logic [K*UW-1:0]      rank_q;
  logic signed [EW-1:0] est_q;
  logic signed [EW-1:0] e1 [K];

  logic [UW-1:0]        cur_user;
  logic                 sgn, last_idx, wr_en;
  logic signed [EW-1:0] e1_sel, est_next;
  logic signed [DW-1:0] e1_x, est_x, delta;
  logic signed [CW-1:0] upd;

  assign cur_user = rank_q[pos*UW +: UW];
  assign last_idx = (idx == IW'(N-1));
  assign e1_sel   = e1[cur_user];
  assign e1_x     = {e1_sel[EW-1], e1_sel};
  assign est_x    = {est_q[EW-1], est_q};

  // restore in second-sweep scan, remove in cancel pass
  always_comb begin
    delta = '0;
    if (state == ST_SCAN && stage) delta = sgn ? e1_x : -e1_x;
    else if (state == ST_CANCEL)   delta = sgn ? -est_x : est_x;
  end
  assign wr_en = (state == ST_SCAN && stage) || (state == ST_CANCEL);

  sic_chip_buf #(.N(N), .CW(CW), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_en(in_valid && in_ready), .load_data(in_sample),
    .ptr_clr(start && state == ST_IDLE),
    .acc_idx(idx), .wr_en(wr_en), .delta(delta), .upd(upd)
  );

  sic_code_store #(.N(N), .K(K)) u_codes (
    .clk(clk), .rst_n(rst_n),
    .load_en(code_valid && code_ready), .load_user(code_user), .load_bits(code_bits),
    .rd_user(cur_user), .rd_idx(idx), .sgn(sgn)
  );

  sic_despread #(.N(N), .CW(CW), .EW(EW)) u_corr (
    .clk(clk), .rst_n(rst_n),
    .en(state == ST_SCAN), .first(idx == '0), .sgn(sgn), .chip(upd),
    .est_next(est_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      stage  <= 1'b0;
      pos    <= '0;
      idx    <= '0;
      rank_q <= '0;
      est_q  <= '0;
      for (int k = 0; k < K; k++) e1[k] <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          rank_q <= rank_order;
          stage  <= 1'b0;
          pos    <= '0;
          idx    <= '0;
          state  <= ST_SCAN;
        end
        ST_SCAN: begin
          idx <= idx + 1'b1;
          if (last_idx) begin
            idx   <= '0;
            est_q <= est_next;
            if (!stage) begin
              e1[cur_user] <= est_next;
              state <= ST_CANCEL;
            end else begin
              state <= ST_EMIT;
            end
          end
        end
        ST_EMIT: if (est_ready) state <= ST_CANCEL;
        ST_CANCEL: begin
          idx <= idx + 1'b1;
          if (last_idx) begin
            idx <= '0;
            if (pos == UW'(K-1)) begin
              pos <= '0;
              if (!stage) begin
                stage <= 1'b1;
                state <= ST_SCAN;
              end else begin
                state <= ST_FIN;
              end
            end else begin
              pos   <= pos + 1'b1;
              state <= ST_SCAN;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);
  assign in_ready   = !busy;
  assign code_ready = !busy;
  assign est_valid  = (state == ST_EMIT);
  assign est_user   = cur_user;
  assign est_value  = est_q;

  // checker state: emitted estimates in the current job
  logic [UW:0] emit_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         emit_cnt <= '0;
    else if (state == ST_IDLE && start) emit_cnt <= '0;
    else if (est_valid && est_ready)    emit_cnt <= emit_cnt + 1'b1;
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid && !est_ready |=> est_valid && $stable(est_user) && $stable(est_value));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r8_emit_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> emit_cnt == (UW+1)'(K));

  a_r8_second_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> stage);

  a_r10_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/sic_engine_tb.sv
module sic_engine_tb;
  localparam int N  = 16;
  localparam int K  = 4;
  localparam int UW = 2;
  localparam int LG = 4;
  localparam int RUN_CYC = 2*N*K + (2*N+1)*K;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [7:0]      in_sample = '0;
  logic            code_valid = 1'b0;
  logic            code_ready;
  logic [UW-1:0]   code_user = '0;
  logic [N-1:0]    code_bits = '0;
  logic [K*UW-1:0] rank_order = '0;
  logic            start = 1'b0;
  logic            busy, done, est_valid;
  logic            est_ready = 1'b1;
  logic [UW-1:0]   est_user;
  logic [5:0]      est_value;

  sic_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .code_valid(code_valid), .code_ready(code_ready), .code_user(code_user), .code_bits(code_bits),
    .rank_order(rank_order), .start(start), .busy(busy), .done(done),
    .est_valid(est_valid), .est_ready(est_ready), .est_user(est_user), .est_value(est_value)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // back-pressure source, updated with NBA so the DUT sees a settled value
  always @(posedge clk) est_ready <= bp_on ? 1'($urandom % 2) : 1'b1;

  // output collector at the falling edge
  int got_user [1024];
  int got_val  [1024];
  int n_got = 0;
  bit prev_wait = 1'b0;
  int prev_u, prev_v;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait)
        chk(est_valid && est_user == UW'(prev_u) && $signed(est_value) == prev_v,
            "R9 held offer", $signed(est_value), prev_v);
      if (est_valid && est_ready && n_got < 1024) begin
        got_user[n_got] = est_user;
        got_val[n_got]  = $signed(est_value);
        n_got++;
      end
      prev_wait = est_valid && !est_ready;
      prev_u = est_user;
      prev_v = $signed(est_value);
    end
  end

  // model inputs and expected outputs
  int           chips_m [N];
  bit [N-1:0]   codes_m [K];
  int           rank_m  [K];
  int           exp_val [K];

  function automatic int clip(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic ref_model();
    int r [N];
    int e1 [K];
    for (int i = 0; i < N; i++) r[i] = chips_m[i];
    for (int k = 0; k < K; k++) e1[k] = 0;
    for (int st = 0; st < 2; st++) begin
      for (int j = 0; j < K; j++) begin
        int u, acc, e;
        u = rank_m[j];
        acc = 0;
        for (int i = 0; i < N; i++) begin
          int s;
          s = codes_m[u][i] ? 1 : -1;
          if (st == 1) r[i] = clip(r[i] + s*e1[u], -128, 127);
          acc += s * r[i];
        end
        e = clip(acc >>> LG, -32, 31);
        if (st == 0) e1[u] = e; else exp_val[j] = e;
        for (int i = 0; i < N; i++) begin
          int s;
          s = codes_m[u][i] ? 1 : -1;
          r[i] = clip(r[i] - s*e, -128, 127);
        end
      end
    end
  endtask

  task automatic run_job(input bit noisy, input string tag);
    int base, cyc;
    for (int u = 0; u < K; u++) begin
      @(negedge clk);
      code_valid = 1'b1; code_user = UW'(u); code_bits = codes_m[u];
      chk(code_ready, "R3 code_ready idle", code_ready, 1);
    end
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      code_valid = 1'b0;
      in_valid = 1'b1; in_sample = 8'(chips_m[i]);
      chk(in_ready, "R2 in_ready idle", in_ready, 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 0; j < K; j++) rank_order[j*UW +: UW] = UW'(rank_m[j]);
    ref_model();
    base = n_got;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (noisy && cyc >= 20 && cyc < 30) begin
        chk(!in_ready && !code_ready, "R2/R3 ready low while busy", in_ready, 0);
        start = 1'b1;
        in_valid = 1'b1; in_sample = 8'($urandom);
        code_valid = 1'b1; code_user = UW'($urandom); code_bits = N'($urandom);
      end else begin
        start = 1'b0; in_valid = 1'b0; code_valid = 1'b0;
      end
    end
    chk(done, {"R11 done seen ", tag}, done, 1);
    if (!bp_on) chk(cyc == RUN_CYC, {"R12 job length ", tag}, cyc, RUN_CYC);
    @(negedge clk);
    chk(!done && !busy, "R11 done one cycle then idle", done, 0);
    chk(n_got - base == K, {"R8 estimate count ", tag}, n_got - base, K);
    for (int j = 0; j < K; j++) begin
      chk(got_user[base+j] == rank_m[j], {"R4 order ", tag}, got_user[base+j], rank_m[j]);
      chk(got_val[base+j] == exp_val[j], {"R5/R6/R7 estimate ", tag}, got_val[base+j], exp_val[j]);
    end
  endtask

  task automatic rand_data(input int lo, input int hi);
    for (int i = 0; i < N; i++) chips_m[i] = lo + int'($urandom % (hi - lo + 1));
    for (int k = 0; k < K; k++) codes_m[k] = N'($urandom);
  endtask

  initial begin
    int fact;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !est_valid, "R1 idle outputs low", busy, 0);
    chk(in_ready && code_ready, "R1 loaders ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !est_valid && in_ready, "R1 after release", busy, 0);

    // single user of amplitude 20, identity rank
    for (int k = 0; k < K; k++) begin codes_m[k] = N'($urandom); rank_m[k] = k; end
    for (int i = 0; i < N; i++) chips_m[i] = codes_m[0][i] ? 20 : -20;
    run_job(1'b0, "single user");
    chk(got_val[0] == 20, "R7 restored user at full amplitude", got_val[0], 20);
    chk(got_val[1] == 0, "R6 cancelled residual gives zero", got_val[1], 0);

    // all-zero codes mean -1 on every chip
    for (int k = 0; k < K; k++) begin codes_m[k] = '0; rank_m[k] = k; end
    for (int i = 0; i < N; i++) chips_m[i] = 10;
    run_job(1'b0, "zero codes");
    chk(got_val[n_got-K] == -10, "R3 bit 0 is minus one", got_val[n_got-K], -10);

    // small values where the floor shift matters
    rand_data(-3, 3);
    run_job(1'b0, "R5 floor");

    // sweep every rank permutation, alternating back-pressure
    fact = 1;
    for (int j = 2; j <= K; j++) fact *= j;
    for (int p = 0; p < fact; p++) begin
      int avail [K];
      int c, cnt;
      for (int j = 0; j < K; j++) avail[j] = j;
      c = p; cnt = K;
      for (int j = 0; j < K; j++) begin
        int sel;
        sel = c % cnt; c = c / cnt;
        rank_m[j] = avail[sel];
        for (int m = sel; m < K-1; m++) avail[m] = avail[m+1];
        cnt--;
      end
      rand_data(-100, 100);
      bp_on = p[0];
      run_job(1'b0, "R4 permutation");
    end

    // near full-scale windows: restores and cancels clip
    bp_on = 1'b0;
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < N; i++) chips_m[i] = ($urandom % 2) ? 127 : -128;
      codes_m[0] = N'($urandom);
      for (int k = 1; k < K; k++) codes_m[k] = (t < 2) ? codes_m[0] : ~codes_m[0];
      for (int k = 0; k < K; k++) rank_m[k] = (k + t) % K;
      run_job(1'b0, "R6/R7 saturation");
    end

    // start, chips and codes driven while busy
    rand_data(-120, 120);
    for (int k = 0; k < K; k++) rank_m[k] = K - 1 - k;
    run_job(1'b1, "R10 start while busy");
    bp_on = 1'b1;
    rand_data(-60, 60);
    run_job(1'b1, "R10 busy with back-pressure");
    bp_on = 1'b0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule